// File: doc/BRIEF.md
# Calendar Adjust Mode Controller

This block sits beside a BCD calendar counter chain (second, minute, hour, day, month, year and weekday) and lets a user set the time with two keys. A mode key steps a state machine through a fixed ring of eight states. One state is normal running. The other seven each select one field of the calendar for adjustment. While any field is selected, the block holds the counter chain still. Each press of the adjust key then writes the selected field's value plus one back into the chain, through that counter's preset port. The new value wraps within the field's own legal range. For the day field, that range follows the length of the current month, leap years included.

The block also chooses which half of the calendar an eight-digit display shows. One group is the date: a fixed century, year, month and day. The other is the time: weekday, hour, minute and second. A third key toggles between the two groups. When the state machine enters an adjust state, the display jumps to the group that holds the field being set. All keys arrive as single-cycle pulses that have already been debounced. Segment decoding happens downstream.

Top module: `cal_adjust_ctrl`

## Requirements
- R1: After reset the controller is in normal mode (modeCode 0), runEn is 1, showDate is 0 (time group) and loadStb is all zero.
- R2: Each modeKey pulse advances modeCode by one through the ring 0 normal, 1 second, 2 minute, 3 hour, 4 day, 5 month, 6 year, 7 weekday, and from 7 back to 0.
- R3: runEn is 1 exactly when modeCode is 0, and is 0 in every adjust mode.
- R4: In normal mode an adjKey pulse produces no load strobe.
- R5: In an adjust mode, an adjKey pulse makes loadStb carry a single set bit for one cycle, in the cycle after the press. The bit positions are 0 second, 1 minute, 2 hour, 3 day, 4 month, 5 year, 6 weekday. In that same cycle loadData holds the field's BCD value plus one, with these wraps: second and minute 59 to 00, hour 23 to 00, month 12 to 01, year 99 to 00, weekday 6 to 0.
- R6: The day field counts up in BCD and wraps to 01 once it reaches the current month's length. That length is 31, 30 for months 04, 06, 09 and 11, and 28 for month 02, or 29 when the two-digit year is divisible by four.
- R7: When a modeKey pulse enters an adjust mode, showDate becomes 1 for the day, month and year modes and 0 for the second, minute, hour and weekday modes. A modeKey pulse that returns to normal leaves showDate unchanged.
- R8: A groupKey pulse without a modeKey pulse in the same cycle toggles showDate.
- R9: digits shows eight BCD nibbles, most significant first. The date group is 2, 0, year, month, day. The time group is 0, weekday, hour, minute, second.
- R10: If modeKey and adjKey arrive in the same cycle, the mode advances and no load strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeKey | input | 1 | Debounced mode key pulse |
| adjKey | input | 1 | Debounced adjust key pulse |
| groupKey | input | 1 | Debounced display group key pulse |
| secIn | input | 8 | Current seconds, BCD |
| minIn | input | 8 | Current minutes, BCD |
| hourIn | input | 8 | Current hours, BCD |
| dayIn | input | 8 | Current day of month, BCD |
| monthIn | input | 8 | Current month, BCD |
| yearIn | input | 8 | Current two-digit year, BCD |
| weekIn | input | 4 | Current weekday, 0 to 6 |
| runEn | output | 1 | Count enable for the calendar chain |
| modeCode | output | 3 | Current mode, 0 normal, 1 to 7 field adjust |
| loadStb | output | 7 | One-cycle preset strobe per field |
| loadData | output | 8 | Preset value for the strobed field |
| showDate | output | 1 | 1 shows the date group, 0 the time group |
| digits | output | 32 | Eight BCD display nibbles |

## Verification
The hardest case to reach from the ports is the day wrap for February. The day must sit at 28 or 29 and the year must be leap or not. Then the mode key has to be pressed exactly four times before an adjust press arrives. The bench acts as the counter chain and applies every load strobe to its own field model, so repeated presses walk values up to their wrap points. It also preloads directed values, such as February 28 in a leap and a non-leap year, the last day of 30- and 31-day months, and the top of each other field. A long random key sequence then mixes simultaneous mode, adjust and group presses.

// File: rtl/caladj_pkg.sv
package caladj_pkg;

  localparam int FIELD_N = 7;
  localparam int BCD_W   = 8;

  typedef enum logic [2:0] {
    M_NORM  = 3'd0,
    M_SEC   = 3'd1,
    M_MIN   = 3'd2,
    M_HOUR  = 3'd3,
    M_DAY   = 3'd4,
    M_MONTH = 3'd5,
    M_YEAR  = 3'd6,
    M_WEEK  = 3'd7
  } mode_e;

  typedef struct packed {
    logic               adjGo;
    logic [FIELD_N-1:0] fieldSel;
  } adjStb_t;

  function automatic logic isDateMode(input mode_e m);
    return (m == M_DAY) || (m == M_MONTH) || (m == M_YEAR);
  endfunction

  // BCD increment, wrapping to lo once the value has reached hi
  function automatic logic [BCD_W-1:0] bcdWrapInc(input logic [BCD_W-1:0] v,
                                                  input logic [BCD_W-1:0] lo,
                                                  input logic [BCD_W-1:0] hi);
    logic [BCD_W-1:0] r;
    if (v >= hi)            r = lo;
    else if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                    r = v + 8'd1;
    return r;
  endfunction

  // month length in BCD; leap when the BCD year is divisible by four
  function automatic logic [BCD_W-1:0] monthLen(input logic [BCD_W-1:0] mon,
                                                input logic [BCD_W-1:0] yr);
    logic leap;
    leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                 : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/caladj_ctrl.sv
module caladj_ctrl
  import caladj_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    modeKey,
  input  logic    adjKey,
  input  logic    groupKey,
  output mode_e   mode,
  output logic    runEn,
  output logic    showDate,
  output adjStb_t stb
);

  mode_e nextMode;
  assign nextMode = mode_e'(mode + 3'd1);
  assign runEn    = (mode == M_NORM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= M_NORM;
      showDate <= 1'b0;
    end else if (modeKey) begin
      mode <= nextMode;
      if (nextMode != M_NORM) showDate <= isDateMode(nextMode);
    end else if (groupKey) begin
      showDate <= ~showDate;
    end
  end

  always_comb begin
    stb = '0;
    if (adjKey && !modeKey && (mode != M_NORM)) begin
      stb.adjGo = 1'b1;
      for (int i = 0; i < FIELD_N; i++)
        stb.fieldSel[i] = (mode == mode_e'(3'(i + 1)));
    end
  end

  // R2
  mode_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeKey |=> (mode == mode_e'($past(mode) + 3'd1)));

  // R7
  auto_group_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeKey && mode == M_MONTH) |=> showDate);

  // R3
  run_resume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeKey && mode == M_WEEK) |=> runEn);

  // R10
  key_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeKey |-> !stb.adjGo);

endmodule

// File: rtl/caladj_datapath.sv
module caladj_datapath
  import caladj_pkg::*;
#(
  parameter int                WEEK_W  = 4,
  parameter int                DIGIT_N = 8,
  parameter logic [BCD_W-1:0]  CENTURY = 8'h20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  adjStb_t              stb,
  input  logic                 showDate,
  input  logic [BCD_W-1:0]     secIn,
  input  logic [BCD_W-1:0]     minIn,
  input  logic [BCD_W-1:0]     hourIn,
  input  logic [BCD_W-1:0]     dayIn,
  input  logic [BCD_W-1:0]     monthIn,
  input  logic [BCD_W-1:0]     yearIn,
  input  logic [WEEK_W-1:0]    weekIn,
  output logic [FIELD_N-1:0]   loadStb,
  output logic [BCD_W-1:0]     loadData,
  output logic [DIGIT_N*4-1:0] digits
);

  localparam int WEEK_PAD = 2 * 4 - WEEK_W;

  logic [BCD_W-1:0] curV [FIELD_N];
  logic [BCD_W-1:0] loV  [FIELD_N];
  logic [BCD_W-1:0] hiV  [FIELD_N];
  logic [BCD_W-1:0] nxtV [FIELD_N];
  logic [BCD_W-1:0] selData;

  always_comb begin
    curV[0] = secIn;   loV[0] = 8'h00; hiV[0] = 8'h59;
    curV[1] = minIn;   loV[1] = 8'h00; hiV[1] = 8'h59;
    curV[2] = hourIn;  loV[2] = 8'h00; hiV[2] = 8'h23;
    curV[3] = dayIn;   loV[3] = 8'h01; hiV[3] = monthLen(monthIn, yearIn);
    curV[4] = monthIn; loV[4] = 8'h01; hiV[4] = 8'h12;
    curV[5] = yearIn;  loV[5] = 8'h00; hiV[5] = 8'h99;
    curV[6] = {{(BCD_W-WEEK_W){1'b0}}, weekIn};
    loV[6]  = 8'h00;   hiV[6] = 8'h06;
  end

  for (genvar g = 0; g < FIELD_N; g++) begin : g_inc
    assign nxtV[g] = bcdWrapInc(curV[g], loV[g], hiV[g]);
  end

  always_comb begin
    selData = '0;
    for (int i = 0; i < FIELD_N; i++)
      if (stb.fieldSel[i]) selData = selData | nxtV[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadStb  <= '0;
      loadData <= '0;
    end else begin
      loadStb <= stb.adjGo ? stb.fieldSel : '0;
      if (stb.adjGo) loadData <= selData;
    end
  end

  assign digits = showDate ? {CENTURY, yearIn, monthIn, dayIn}
                           : {{WEEK_PAD{1'b0}}, weekIn, hourIn, minIn, secIn};

  // R5
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadStb));

  // R5
  bcd_digit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb != '0) |-> (loadData[3:0] <= 4'd9));

  // R6
  day_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStb[3] |-> (loadData != 8'h00 && loadData <= 8'h31));

endmodule

// File: rtl/cal_adjust_ctrl.sv
module cal_adjust_ctrl
  import caladj_pkg::*;
#(
  parameter int          WEEK_W  = 4,
  parameter int          DIGIT_N = 8,
  parameter logic [7:0]  CENTURY = 8'h20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modeKey,
  input  logic                 adjKey,
  input  logic                 groupKey,
  input  logic [7:0]           secIn,
  input  logic [7:0]           minIn,
  input  logic [7:0]           hourIn,
  input  logic [7:0]           dayIn,
  input  logic [7:0]           monthIn,
  input  logic [7:0]           yearIn,
  input  logic [WEEK_W-1:0]    weekIn,
  output logic                 runEn,
  output logic [2:0]           modeCode,
  output logic [6:0]           loadStb,
  output logic [7:0]           loadData,
  output logic                 showDate,
  output logic [DIGIT_N*4-1:0] digits
);

  mode_e   mode;
  adjStb_t stb;

  caladj_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeKey  (modeKey),
    .adjKey   (adjKey),
    .groupKey (groupKey),
    .mode     (mode),
    .runEn    (runEn),
    .showDate (showDate),
    .stb      (stb)
  );

  caladj_datapath #(
    .WEEK_W  (WEEK_W),
    .DIGIT_N (DIGIT_N),
    .CENTURY (CENTURY)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .showDate (showDate),
    .secIn    (secIn),
    .minIn    (minIn),
    .hourIn   (hourIn),
    .dayIn    (dayIn),
    .monthIn  (monthIn),
    .yearIn   (yearIn),
    .weekIn   (weekIn),
    .loadStb  (loadStb),
    .loadData (loadData),
    .digits   (digits)
  );

  assign modeCode = mode;

  // R4
  normal_no_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb != '0) |-> $past(modeCode != 3'd0));

endmodule

// File: tb/cal_adjust_ctrl_tb.sv
`timescale 1ns/1ps
module cal_adjust_ctrl_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeKey = 1'b0, adjKey = 1'b0, groupKey = 1'b0;
  logic [7:0] secIn = 8'h00, minIn = 8'h00, hourIn = 8'h00;
  logic [7:0] dayIn = 8'h01, monthIn = 8'h01, yearIn = 8'h00;
  logic [3:0] weekIn = 4'h0;
  logic runEn, showDate;
  logic [2:0] modeCode;
  logic [6:0] loadStb;
  logic [7:0] loadData;
  logic [31:0] digits;

  int checks = 0, errors = 0;
  int expMode = 0;
  bit expDate = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cal_adjust_ctrl u_dut (
    .clk(clk), .rstN(rstN), .modeKey(modeKey), .adjKey(adjKey), .groupKey(groupKey),
    .secIn(secIn), .minIn(minIn), .hourIn(hourIn), .dayIn(dayIn), .monthIn(monthIn),
    .yearIn(yearIn), .weekIn(weekIn), .runEn(runEn), .modeCode(modeCode),
    .loadStb(loadStb), .loadData(loadData), .showDate(showDate), .digits(digits)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int daysIn(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] refInc(input int m);
    int v, lo, hi;
    case (m)
      1: begin v = b2i(secIn);  lo = 0; hi = 59; end
      2: begin v = b2i(minIn);  lo = 0; hi = 59; end
      3: begin v = b2i(hourIn); lo = 0; hi = 23; end
      4: begin v = b2i(dayIn);  lo = 1; hi = daysIn(b2i(monthIn), b2i(yearIn)); end
      5: begin v = b2i(monthIn); lo = 1; hi = 12; end
      6: begin v = b2i(yearIn); lo = 0; hi = 99; end
      default: begin v = int'(weekIn); lo = 0; hi = 6; end
    endcase
    return i2b((v >= hi) ? lo : v + 1);
  endfunction

  function automatic bit refIsDate(input int m);
    return (m == 4 || m == 5 || m == 6);
  endfunction

  task automatic step(input bit m, input bit a, input bit g);
    logic [6:0] eStb;
    logic [7:0] eData;
    int preMode;
    @(negedge clk);
    modeKey = m; adjKey = a; groupKey = g;
    preMode = expMode;
    eStb = '0; eData = 8'h00;
    if (a && !m && expMode != 0) begin
      eStb[expMode-1] = 1'b1;
      eData = refInc(expMode);
    end
    if (m) begin
      expMode = (expMode + 1) % 8;
      if (expMode != 0) expDate = refIsDate(expMode);
    end else if (g) expDate = !expDate;
    @(posedge clk);
    #1;
    modeKey = 1'b0; adjKey = 1'b0; groupKey = 1'b0;
    chk(modeCode == 3'(expMode), "R2", 32'(modeCode), 32'(expMode));
    chk(runEn == (expMode == 0), "R3", 32'(runEn), 32'(expMode == 0));
    chk(showDate == expDate, m ? "R7" : "R8", 32'(showDate), 32'(expDate));
    if (a && m)
      chk(loadStb == eStb, "R10", 32'(loadStb), 32'(eStb));
    else if (a && preMode == 0)
      chk(loadStb == eStb, "R4", 32'(loadStb), 32'(eStb));
    else
      chk(loadStb == eStb, "R5", 32'(loadStb), 32'(eStb));
    if (eStb != '0) begin
      chk(loadData == eData, (preMode == 4) ? "R6" : "R5", 32'(loadData), 32'(eData));
      case (preMode)
        1: secIn = eData;
        2: minIn = eData;
        3: hourIn = eData;
        4: dayIn = eData;
        5: monthIn = eData;
        6: yearIn = eData;
        default: weekIn = eData[3:0];
      endcase
    end
    #1;
    begin
      logic [31:0] eDig;
      eDig = expDate ? {8'h20, yearIn, monthIn, dayIn} : {4'h0, weekIn, hourIn, minIn, secIn};
      chk(digits == eDig, "R9", digits, eDig);
    end
  endtask

  task automatic goMode(input int t);
    while (expMode != t) step(1'b1, 1'b0, 1'b0);
  endtask

  task automatic setFields(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y,
                           input logic [3:0] w);
    @(negedge clk);
    secIn = s; minIn = mi; hourIn = h; dayIn = d; monthIn = mo; yearIn = y; weekIn = w;
  endtask

  task automatic randFields();
    int mo, yr;
    mo = 1 + int'($urandom % 12);
    yr = int'($urandom % 100);
    setFields(i2b(int'($urandom % 60)), i2b(int'($urandom % 60)), i2b(int'($urandom % 24)),
              i2b(1 + int'($urandom % daysIn(mo, yr))), i2b(mo), i2b(yr), 4'($urandom % 7));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk(modeCode == 3'd0, "R1", 32'(modeCode), 0);
    chk(runEn == 1'b1, "R1", 32'(runEn), 1);
    chk(showDate == 1'b0, "R1", 32'(showDate), 0);
    chk(loadStb == '0, "R1", 32'(loadStb), 0);

    // R4 adjust in normal mode
    step(1'b0, 1'b1, 1'b0);
    // R2 full ring
    repeat (8) step(1'b1, 1'b0, 1'b0);

    // R6 February, non-leap and leap
    setFields(8'h10, 8'h20, 8'h05, 8'h28, 8'h02, 8'h23, 4'h3);
    goMode(4);
    step(1'b0, 1'b1, 1'b0);
    setFields(8'h10, 8'h20, 8'h05, 8'h28, 8'h02, 8'h24, 4'h3);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    setFields(8'h10, 8'h20, 8'h05, 8'h30, 8'h04, 8'h24, 4'h3);
    step(1'b0, 1'b1, 1'b0);
    setFields(8'h10, 8'h20, 8'h05, 8'h30, 8'h12, 8'h24, 4'h3);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    setFields(8'h10, 8'h20, 8'h05, 8'h29, 8'h02, 8'h00, 4'h3);
    step(1'b0, 1'b1, 1'b0);

    // R5 top-of-range wraps
    setFields(8'h59, 8'h59, 8'h23, 8'h15, 8'h12, 8'h99, 4'h6);
    goMode(1); step(1'b0, 1'b1, 1'b0);
    goMode(2); step(1'b0, 1'b1, 1'b0);
    goMode(3); step(1'b0, 1'b1, 1'b0);
    goMode(5); step(1'b0, 1'b1, 1'b0);
    goMode(6); step(1'b0, 1'b1, 1'b0);
    goMode(7); step(1'b0, 1'b1, 1'b0);
    setFields(8'h09, 8'h19, 8'h09, 8'h09, 8'h09, 8'h49, 4'h2);
    goMode(1); step(1'b0, 1'b1, 1'b0);

    // R10 clash, R8 group toggle inside adjust mode
    step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    goMode(0);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);

    for (int it = 0; it < 4000; it++) begin
      int r;
      r = int'($urandom % 10);
      if (expMode == 0 && ($urandom % 6) == 0) randFields();
      case (r)
        0, 1:    step(1'b1, 1'b0, 1'b0);
        2, 3, 4, 5, 6: step(1'b0, 1'b1, 1'b0);
        7:       step(1'b0, 1'b0, 1'b1);
        8:       step(1'b1, 1'b1, ($urandom % 2) == 0);
        default: step(1'b0, 1'b0, 1'b0);
      endcase
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule